// File: doc/BRIEF.md
# Threshold-Gated DMA Burst Splitter

This block sits in the request side of a port DMA that moves frame data between a local FIFO and system memory. Software or a frame engine hands it a start address, a frame length in DWORDs and a direction. In receive, data goes from the FIFO into memory as bus writes. In transmit, data is read from memory into the FIFO. The block holds off each transfer unit until the FIFO is ready. It then cuts the unit into bus bursts and presents each burst as an address, a DWORD length and a write flag on a request/acknowledge interface.

A transfer unit is the programmed transaction size for that direction, capped at the burst maximum for that direction. In receive, a unit is released once the FIFO holds enough data. An end-of-frame marker also releases it, so a short tail can be flushed. In transmit, a unit is released once the FIFO has room for all of it. Within a unit, bursts are split at the burst maximum and at naturally aligned address windows of `BOUND_BYTES` (1 KB by default). Split points also fall where the unit ends and where the frame ends.

Top module: `xfer_burst_gen`

## Requirements
- R1: `start` is accepted only while `busy` is low. `busy` rises on the cycle after acceptance and stays high until the cycle after `done`. A `start` seen while busy does not change the frame being moved.
- R2: Each burst length is the minimum of three values: the DWORDs still owed in the current unit, the DWORDs left before the next `BOUND_BYTES` window edge, and the effective burst maximum. It is never zero.
- R3: The effective burst maximum is `cfgWrMax` in receive and `cfgRdMax` in transmit. A programmed value of 0 acts as 1.
- R4: No burst crosses a `BOUND_BYTES` aligned address window: (address offset within the window)/4 plus `reqLen` is at most `BOUND_BYTES`/4.
- R5: In receive, while no end-of-frame marker is present, no unit is requested until `rxLevel` is at least the effective receive unit size.
- R6: In receive, `rxEof` high releases the gate as soon as `rxLevel` covers the rest of the unit, even when that is below the receive unit size.
- R7: In transmit, a unit is requested only when `txFree` is at least the unit length, and the last unit of a frame is shortened to the DWORDs left.
- R8: The effective unit size is `cfgRxUnit` or `cfgTxUnit` (0 acts as 1), capped at the effective burst maximum of that direction.
- R9: `reqAddr`, `reqLen` and `reqWrite` hold steady while `reqValid` is high without `reqAck`. Each acknowledged burst advances the address by 4×`reqLen`, starting at `startAddr` with its low two bits cleared.
- R10: `done` pulses high for one cycle, on the cycle after the acknowledge of the final burst. A zero-length frame gives `done` on the cycle after acceptance, with no request.
- R11: `reqWrite` is 1 for receive (`startDirTx`=0) and 0 for transmit (`startDirTx`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (accepted when idle) |
| startDirTx | input | 1 | 0 = receive (FIFO to memory), 1 = transmit |
| startAddr | input | AW | Frame start byte address |
| frameLen | input | LW | Frame length in DWORDs |
| cfgRdMax | input | BW | Maximum memory-read burst, DWORDs |
| cfgWrMax | input | BW | Maximum memory-write burst, DWORDs |
| cfgRxUnit | input | LW | Receive transaction size, DWORDs |
| cfgTxUnit | input | LW | Transmit transaction size, DWORDs |
| rxLevel | input | LVW | Receive FIFO fill, DWORDs |
| rxEof | input | 1 | End-of-frame marker present in the receive FIFO |
| txFree | input | LVW | Transmit FIFO free space, DWORDs |
| reqValid | output | 1 | Burst request valid |
| reqAddr | output | AW | Burst byte address |
| reqLen | output | LW | Burst length, DWORDs |
| reqWrite | output | 1 | 1 = memory write, 0 = memory read |
| reqAck | input | 1 | Bus accepted the burst |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame completion pulse |

## Verification
The bench builds the block with a 64-byte window, a 5-bit burst maximum and 8-bit lengths and levels. With this build, window crossings occur within a few bursts, and every start offset inside a window can be swept. The sweep covers both directions, zero and small burst limits, and unit sizes below, equal to and above the cap, together with empty, single-DWORD and multi-window frames. Directed runs starve and then release the receive level, the end-of-frame marker and the transmit free space. Other directed runs hold back the acknowledge, and issue a second start while busy.

// File: rtl/xfer_burst_pkg.sv
package xfer_burst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GATE,
    ST_ISSUE,
    ST_DONE
  } ctrlState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;      // capture a new frame
    logic takeUnit;  // open the next transfer unit
    logic advance;   // current burst acknowledged
  } dpStrobe_t;
endpackage

// File: rtl/xfer_burst_dp.sv
module xfer_burst_dp
  import xfer_burst_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int BW = 8,
  parameter int LVW = 10,
  parameter int BOUND_BYTES = 1024
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpStrobe_t      strobe,
  input  logic           startDirTx,
  input  logic [AW-1:0]  startAddr,
  input  logic [LW-1:0]  frameLen,
  input  logic [BW-1:0]  cfgRdMax,
  input  logic [BW-1:0]  cfgWrMax,
  input  logic [LW-1:0]  cfgRxUnit,
  input  logic [LW-1:0]  cfgTxUnit,
  input  logic [LVW-1:0] rxLevel,
  input  logic           rxEof,
  input  logic [LVW-1:0] txFree,
  output logic [AW-1:0]  reqAddr,
  output logic [LW-1:0]  reqLen,
  output logic           reqWrite,
  output logic           frameEmpty,
  output logic           gateOpen,
  output logic           unitLast,
  output logic           frameLast
);
  localparam int BND_LOG = $clog2(BOUND_BYTES);
  localparam int BND_DW = BOUND_BYTES / 4;
  localparam int W1 = (LW > LVW) ? LW : LVW;
  localparam int W2 = (W1 > BW) ? W1 : BW;
  localparam int CW = ((W2 > BND_LOG) ? W2 : BND_LOG) + 1;

  logic [AW-1:0] addrQ;
  logic [LW-1:0] remainQ;
  logic [LW-1:0] unitRemQ;
  logic          dirTxQ;

  logic [CW-1:0] maxSel, effMax, unitSel, unitCfg, effUnit;
  logic [CW-1:0] remainW, unitLen, bndLeft, unitRemW, burstTmp, burstLen;
  logic [CW-1:0] rxLvlW, txFreeW;

  always_comb begin
    // effective burst maximum for the latched direction, zero acts as one
    maxSel  = dirTxQ ? CW'(cfgRdMax) : CW'(cfgWrMax);
    effMax  = (maxSel == '0) ? CW'(1) : maxSel;
    // effective unit size, capped at the burst maximum
    unitSel = dirTxQ ? CW'(cfgTxUnit) : CW'(cfgRxUnit);
    unitCfg = (unitSel == '0) ? CW'(1) : unitSel;
    effUnit = (unitCfg < effMax) ? unitCfg : effMax;
    // next unit length, shortened at end of frame
    remainW = CW'(remainQ);
    unitLen = (remainW < effUnit) ? remainW : effUnit;
    // FIFO readiness
    rxLvlW  = CW'(rxLevel);
    txFreeW = CW'(txFree);
    if (dirTxQ) gateOpen = (txFreeW >= unitLen);
    else        gateOpen = (rxLvlW >= unitLen) && ((rxLvlW >= effUnit) || rxEof);
    // burst length: min of unit remainder, window remainder and maximum
    bndLeft  = CW'(BND_DW) - CW'(addrQ[BND_LOG-1:2]);
    unitRemW = CW'(unitRemQ);
    burstTmp = (unitRemW < bndLeft) ? unitRemW : bndLeft;
    burstLen = (burstTmp < effMax) ? burstTmp : effMax;
  end

  assign reqAddr    = addrQ;
  assign reqLen     = LW'(burstLen);
  assign reqWrite   = ~dirTxQ;
  assign frameEmpty = (frameLen == '0);
  assign unitLast   = (burstLen == unitRemW);
  assign frameLast  = (burstLen == remainW);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      remainQ  <= '0;
      unitRemQ <= '0;
      dirTxQ   <= 1'b0;
    end else if (strobe.load) begin
      addrQ    <= startAddr & ~AW'(3);
      remainQ  <= frameLen;
      unitRemQ <= '0;
      dirTxQ   <= startDirTx;
    end else if (strobe.takeUnit) begin
      unitRemQ <= LW'(unitLen);
    end else if (strobe.advance) begin
      addrQ    <= addrQ + (AW'(burstLen) << 2);
      remainQ  <= remainQ - LW'(burstLen);
      unitRemQ <= unitRemQ - LW'(burstLen);
    end
  end
endmodule

// File: rtl/xfer_burst_ctrl.sv
module xfer_burst_ctrl
  import xfer_burst_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      reqAck,
  input  logic      frameEmpty,
  input  logic      gateOpen,
  input  logic      unitLast,
  input  logic      frameLast,
  output dpStrobe_t strobe,
  output logic      reqValid,
  output logic      busy,
  output logic      done
);
  ctrlState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: if (start) begin
        strobe.load = 1'b1;
        stateD = frameEmpty ? ST_DONE : ST_GATE;
      end
      ST_GATE: if (gateOpen) begin
        strobe.takeUnit = 1'b1;
        stateD = ST_ISSUE;
      end
      ST_ISSUE: if (reqAck) begin
        strobe.advance = 1'b1;
        if (frameLast)     stateD = ST_DONE;
        else if (unitLast) stateD = ST_GATE;
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign reqValid = (stateQ == ST_ISSUE);
  assign busy     = (stateQ != ST_IDLE);
  assign done     = (stateQ == ST_DONE);
endmodule

// File: rtl/xfer_burst_gen.sv
module xfer_burst_gen
  import xfer_burst_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int BW = 8,
  parameter int LVW = 10,
  parameter int BOUND_BYTES = 1024
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           startDirTx,
  input  logic [AW-1:0]  startAddr,
  input  logic [LW-1:0]  frameLen,
  input  logic [BW-1:0]  cfgRdMax,
  input  logic [BW-1:0]  cfgWrMax,
  input  logic [LW-1:0]  cfgRxUnit,
  input  logic [LW-1:0]  cfgTxUnit,
  input  logic [LVW-1:0] rxLevel,
  input  logic           rxEof,
  input  logic [LVW-1:0] txFree,
  output logic           reqValid,
  output logic [AW-1:0]  reqAddr,
  output logic [LW-1:0]  reqLen,
  output logic           reqWrite,
  input  logic           reqAck,
  output logic           busy,
  output logic           done
);
  dpStrobe_t strobe;
  logic frameEmpty, gateOpen, unitLast, frameLast;

  xfer_burst_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .reqAck(reqAck),
    .frameEmpty(frameEmpty), .gateOpen(gateOpen),
    .unitLast(unitLast), .frameLast(frameLast),
    .strobe(strobe), .reqValid(reqValid), .busy(busy), .done(done)
  );

  xfer_burst_dp #(
    .AW(AW), .LW(LW), .BW(BW), .LVW(LVW), .BOUND_BYTES(BOUND_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startDirTx(startDirTx),
    .startAddr(startAddr), .frameLen(frameLen),
    .cfgRdMax(cfgRdMax), .cfgWrMax(cfgWrMax),
    .cfgRxUnit(cfgRxUnit), .cfgTxUnit(cfgTxUnit),
    .rxLevel(rxLevel), .rxEof(rxEof), .txFree(txFree),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqWrite(reqWrite),
    .frameEmpty(frameEmpty), .gateOpen(gateOpen),
    .unitLast(unitLast), .frameLast(frameLast)
  );
endmodule

// File: rtl/xfer_burst_chk.sv
module xfer_burst_chk #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int BW = 8,
  parameter int BOUND_BYTES = 1024
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic [AW-1:0] reqAddr,
  input logic [LW-1:0] reqLen,
  input logic          reqWrite,
  input logic          reqAck,
  input logic [BW-1:0] cfgRdMax,
  input logic [BW-1:0] cfgWrMax,
  input logic          busy,
  input logic          done
);
  localparam int BND_LOG = $clog2(BOUND_BYTES);
  localparam int BND_DW = BOUND_BYTES / 4;

  logic [BW-1:0] capSel;
  int capEff;
  always_comb begin
    capSel = reqWrite ? cfgWrMax : cfgRdMax;
    capEff = (capSel == '0) ? 1 : int'(capSel);
  end

  assert_len_in_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqLen != '0) && (int'(reqLen) <= capEff));

  assert_no_window_cross_R4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (int'(reqAddr[BND_LOG-1:2]) + int'(reqLen) <= BND_DW));

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqAck |=> reqValid && $stable(reqAddr) && $stable(reqLen) && $stable(reqWrite));

  assert_addr_advance_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqAck |=> !reqValid || (reqAddr == $past(reqAddr) + (AW'($past(reqLen)) << 2)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !reqValid && !done);
endmodule

bind xfer_burst_gen xfer_burst_chk #(
  .AW(AW), .LW(LW), .BW(BW), .BOUND_BYTES(BOUND_BYTES)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
  .reqLen(reqLen), .reqWrite(reqWrite), .reqAck(reqAck),
  .cfgRdMax(cfgRdMax), .cfgWrMax(cfgWrMax), .busy(busy), .done(done)
);

// File: tb/test_xfer_burst_gen.sv
module test_xfer_burst_gen;
  localparam int AW = 16, LW = 8, BW = 5, LVW = 8, BOUND_BYTES = 64;
  localparam int BND_DW = BOUND_BYTES / 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic start = 0, startDirTx = 0, rxEof = 0, reqAck = 0;
  logic [AW-1:0] startAddr = '0;
  logic [LW-1:0] frameLen = '0, cfgRxUnit = '0, cfgTxUnit = '0;
  logic [BW-1:0] cfgRdMax = '0, cfgWrMax = '0;
  logic [LVW-1:0] rxLevel = '0, txFree = '0;
  logic reqValid, reqWrite, busy, done;
  logic [AW-1:0] reqAddr;
  logic [LW-1:0] reqLen;

  xfer_burst_gen #(.AW(AW), .LW(LW), .BW(BW), .LVW(LVW), .BOUND_BYTES(BOUND_BYTES)) i_xfer_burst_gen (
    .clk(clk), .rstN(rstN), .start(start), .startDirTx(startDirTx),
    .startAddr(startAddr), .frameLen(frameLen), .cfgRdMax(cfgRdMax),
    .cfgWrMax(cfgWrMax), .cfgRxUnit(cfgRxUnit), .cfgTxUnit(cfgTxUnit),
    .rxLevel(rxLevel), .rxEof(rxEof), .txFree(txFree),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqLen(reqLen),
    .reqWrite(reqWrite), .reqAck(reqAck), .busy(busy), .done(done)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  int mAddr, mRemain, mUnitRem, mDir;

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction
  function automatic int effMax();
    int m = mDir ? int'(cfgRdMax) : int'(cfgWrMax);
    return (m == 0) ? 1 : m;
  endfunction
  function automatic int effUnit();
    int u = mDir ? int'(cfgTxUnit) : int'(cfgRxUnit);
    if (u == 0) u = 1;
    return imin(u, effMax());
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic startFrame(bit dir, int addr, int len);
    @(negedge clk);
    startDirTx = dir; startAddr = AW'(addr); frameLen = LW'(len); start = 1;
    mAddr = addr & ~3; mRemain = len; mUnitRem = 0; mDir = dir;
    @(negedge clk);
    start = 0;
    check(busy == 1, "R1", "busy after start", busy, 1);
  endtask

  // Services bursts until done, comparing each against the arithmetic model
  task automatic serviceFrame(bit useHold);
    bit expDone = (mRemain == 0);
    int burstIdx = 0, hold = 0, guard = 0, exp;
    forever begin
      check(done == expDone, "R10", "done timing", done, expDone);
      if (done) break;
      if (reqValid) begin
        if (mUnitRem == 0) mUnitRem = imin(mRemain, effUnit());
        exp = imin(mUnitRem, imin(BND_DW - (mAddr % BOUND_BYTES) / 4, effMax()));
        check(int'(reqLen) == exp, "R2", "burst length", reqLen, exp);
        check(int'(reqAddr) == (mAddr & 16'hFFFF), "R9", "burst address", reqAddr, mAddr);
        check(reqWrite == !mDir, "R11", "write flag", reqWrite, !mDir);
        check((int'(reqAddr) % BOUND_BYTES) / 4 + int'(reqLen) <= BND_DW, "R4", "window end",
              (int'(reqAddr) % BOUND_BYTES) / 4 + int'(reqLen), BND_DW);
        if (useHold && (burstIdx % 3 == 1) && hold < 2) begin
          hold++;
        end else begin
          reqAck = 1; hold = 0; burstIdx++;
          mAddr += 4 * exp; mRemain -= exp; mUnitRem -= exp;
          if (mRemain <= 0) expDone = 1;
        end
      end
      @(negedge clk);
      reqAck = 0;
      guard++;
      if (guard > 3000) begin
        check(0, "R10", "frame never completed", 0, 1);
        break;
      end
    end
    @(negedge clk);
    check(busy == 0, "R1", "busy clears after done", busy, 0);
  endtask

  task automatic quietFor(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(reqValid == 0, req, "gate holds request", reqValid, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int lens[5] = '{0, 1, 5, 17, 40};
    int maxs[4] = '{0, 1, 3, 16};
    int units[4] = '{0, 2, 5, 40};
    int offs[5] = '{0, 3, 7, 12, 15};
    repeat (3) @(negedge clk);
    check(reqValid == 0 && busy == 0 && done == 0, "R1", "reset outputs", {reqValid, busy, done}, 0);
    rstN = 1;
    @(negedge clk);
    check(busy == 0, "R1", "idle after reset", busy, 0);

    // Sweep: gates always open, model checks R2/R3/R4/R8/R9/R10/R11
    rxLevel = '1; txFree = '1; rxEof = 0;
    for (int d = 0; d < 2; d++)
      for (int o = 0; o < 5; o++)
        for (int l = 0; l < 5; l++)
          for (int m = 0; m < 4; m++)
            for (int u = 0; u < 4; u++) begin
              cfgRdMax = BW'(d ? maxs[m] : 2);
              cfgWrMax = BW'(d ? 2 : maxs[m]);
              cfgTxUnit = LW'(d ? units[u] : 3);
              cfgRxUnit = LW'(d ? 3 : units[u]);
              startFrame(d[0], 256 + offs[o] * 4 + (u % 2), lens[l]);
              serviceFrame((l + m) % 2 == 1);
            end

    // R3: zero write maximum acts as one DWORD in receive
    cfgWrMax = 0; cfgRdMax = 8; cfgRxUnit = 8; rxLevel = '1;
    startFrame(0, 0, 3);
    @(negedge clk);
    check(reqValid == 1 && reqLen == 1, "R3", "zero max gives 1", reqLen, 1);
    serviceFrame(0);

    // R5: receive gate below threshold, then at threshold; R1 second start ignored
    cfgWrMax = 16; cfgRxUnit = 8; rxLevel = 7; rxEof = 0;
    startFrame(0, 0, 20);
    quietFor(3, "R5");
    start = 1; frameLen = 3; startAddr = 16'h0200;
    @(negedge clk);
    start = 0;
    check(reqValid == 0, "R1", "start while busy", reqValid, 0);
    rxLevel = 8;
    @(negedge clk);
    check(reqValid == 1 && reqLen == 8, "R5", "gate at threshold", reqLen, 8);
    rxLevel = '1;
    serviceFrame(0);

    // R6: short tail waits for end-of-frame marker
    cfgRxUnit = 8; rxLevel = 5; rxEof = 0;
    startFrame(0, 64, 5);
    quietFor(4, "R6");
    rxEof = 1;
    @(negedge clk);
    check(reqValid == 1 && reqLen == 5, "R6", "eof releases tail", reqLen, 5);
    serviceFrame(0);
    rxEof = 0; rxLevel = '1;

    // R7: transmit needs free space for whole unit
    cfgRdMax = 16; cfgTxUnit = 8; txFree = 7;
    startFrame(1, 0, 11);
    quietFor(4, "R7");
    txFree = 8;
    @(negedge clk);
    check(reqValid == 1 && reqLen == 8, "R7", "free space opens gate", reqLen, 8);
    txFree = 3;
    serviceFrame(0);

    // R8: unit larger than maximum is capped, so small free space suffices
    cfgRdMax = 4; cfgTxUnit = 20; txFree = 4;
    startFrame(1, 0, 12);
    @(negedge clk);
    check(reqValid == 1 && reqLen == 4, "R8", "unit capped at max", reqLen, 4);
    serviceFrame(1);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule